// File: doc/BRIEF.md
# Secondary Interrupt Controller with Direct Routing

The block gathers 32 level-sensitive interrupt request lines and drives two kinds of output toward a primary interrupt controller. The first output is a single summary request. It is raised whenever any input that is high also has its bit set in an enable mask, and it appears on output line 31. The second kind is a group of direct routes. Input lines 21 to 30 can each be passed straight through to the output line with the same number, and each route is enabled on its own.

Software reaches the block through a word-addressed register window of 4 KiB on a plain read/write bus. Through it, software can:
- read the raw input levels;
- read the masked status;
- read the enable mask and the routing enables;
- change both enable sets with separate set and clear words, so no read-modify-write is needed.

Two further words act only on mask bit 0. One sets that bit and the other clears it, each on any non-zero write.

Every input is sampled on every clock edge, with no edge latching. All outputs are driven from registered state.

Top module: `sic_secondary`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the level, mask and routing-enable state read as zero and every output line is low.
- R2: A read of word 1 returns the input vector sampled at the previous clock edge (bit n is input n).
- R3: Output line 31 is high exactly when (level AND mask) is non-zero. A read of word 0 returns level AND mask.
- R4: A write to word 2 ORs the data into the mask. A write to word 3 clears the mask bits that are 1 in the data. A read of word 2 returns the mask.
- R5: A write to word 4 with non-zero data sets mask bit 0, and a write to word 5 with non-zero data clears it. Zero data leaves the mask unchanged. A read of word 4 returns level bit 0 in bit 0 and zero elsewhere.
- R6: A write to word 8 ORs (data AND 0x7FE00000) into the routing-enable register, so only bits 21 to 30 can be set. A write to word 9 clears the routing-enable bits that are 1 in the data. A read of word 8 returns the routing-enable register.
- R7: For each line i from 21 to 30, output i equals level bit i while routing-enable bit i is set, and is low while it is clear.
- R8: Output lines 0 to 20 are always low.
- R9: The word index is address bits [11:2]. A read of any word other than 0, 1, 2, 4 and 8 returns 0. A write to any word other than 2, 3, 4, 5, 8 and 9 changes no state.
- R10: An input change or a register write is visible on the outputs and in read data in the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Level-sensitive interrupt requests |
| bus_addr | input | 12 | Byte address within the register window |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational from state |
| irq_out | output | 32 | Line 31 is the summary, lines 21 to 30 are the direct routes, the rest stay low |

## Verification
The bench targets several corner cases, each tied to a distinct failure.

1. Writes to the routing-set word carry data with bits outside 21 to 30. A design that skips the filter would raise routing-enable bits, or output lines, that must stay zero.
2. Soft set and clear writes use zero data. A design that ignores the non-zero rule would toggle mask bit 0.
3. Soft writes are also compared with the mask-set word. A design that confused the soft words with the pending level would show it in word 0 and on line 31.
4. Reads and writes are spread over unlisted word indices, including 6, 7 and those above 9. A loose decoder would return stale data or change state there.
5. The one-cycle lag from input to output is checked each cycle. A design that adds or drops a stage would disagree with the reference model.

// File: rtl/sic_pkg.sv
package sic_pkg;

  localparam int DW = 32;

  // Word indices of the register window
  localparam int W_STATUS  = 0;
  localparam int W_RAW     = 1;
  localparam int W_EN      = 2;
  localparam int W_EN_CLR  = 3;
  localparam int W_SOFT    = 4;
  localparam int W_SOFT_CL = 5;
  localparam int W_ROUTE   = 8;
  localparam int W_ROUTE_C = 9;

  typedef logic [DW-1:0] word_t;

  // Mask with bits lo..hi set
  function automatic word_t range_mask(input int lo, input int hi);
    word_t m;
    m = '0;
    for (int i = 0; i < DW; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic word_t set_bits(input word_t cur, input word_t d);
    return cur | d;
  endfunction

  function automatic word_t clr_bits(input word_t cur, input word_t d);
    return cur & ~d;
  endfunction

  // Soft words act on mask bit 0 when the data is non-zero
  function automatic word_t soft_bit0(input word_t cur, input word_t d,
                                      input logic set);
    word_t r;
    r = cur;
    if (d != '0) r[0] = set;
    return r;
  endfunction

  function automatic word_t masked(input word_t lvl, input word_t msk);
    return lvl & msk;
  endfunction

endpackage

// File: rtl/sic_level_capture.sv
module sic_level_capture
  import sic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t irq_in,
  output word_t level_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= irq_in;
  end

endmodule

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  word_t             bus_wdata,
  input  word_t             level_q,
  output word_t             mask_q,
  output word_t             route_q,
  output word_t             status_w,
  output word_t             bus_rdata
);

  localparam int    WI_W    = ADDR_W - 2;
  localparam word_t PT_MASK = range_mask(PT_LO, PT_HI);

  logic [WI_W-1:0] word;
  assign word = bus_addr[ADDR_W-1:2];

  logic hit_status, hit_raw, hit_en, hit_en_clr;
  logic hit_soft, hit_soft_cl, hit_route, hit_route_c;

  assign hit_status  = (word == WI_W'(W_STATUS));
  assign hit_raw     = (word == WI_W'(W_RAW));
  assign hit_en      = (word == WI_W'(W_EN));
  assign hit_en_clr  = (word == WI_W'(W_EN_CLR));
  assign hit_soft    = (word == WI_W'(W_SOFT));
  assign hit_soft_cl = (word == WI_W'(W_SOFT_CL));
  assign hit_route   = (word == WI_W'(W_ROUTE));
  assign hit_route_c = (word == WI_W'(W_ROUTE_C));

  // Named write events
  logic wr_en_set, wr_en_clr, wr_soft_set, wr_soft_clr;
  logic wr_rt_set, wr_rt_clr, wr_unlisted;

  assign wr_en_set   = bus_wr && hit_en;
  assign wr_en_clr   = bus_wr && hit_en_clr;
  assign wr_soft_set = bus_wr && hit_soft;
  assign wr_soft_clr = bus_wr && hit_soft_cl;
  assign wr_rt_set   = bus_wr && hit_route;
  assign wr_rt_clr   = bus_wr && hit_route_c;
  assign wr_unlisted = bus_wr && !(hit_en || hit_en_clr || hit_soft ||
                                   hit_soft_cl || hit_route || hit_route_c);

  word_t mask_d, route_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en_set)   mask_d = set_bits(mask_q, bus_wdata);
    if (wr_en_clr)   mask_d = clr_bits(mask_q, bus_wdata);
    if (wr_soft_set) mask_d = soft_bit0(mask_q, bus_wdata, 1'b1);
    if (wr_soft_clr) mask_d = soft_bit0(mask_q, bus_wdata, 1'b0);
  end

  always_comb begin
    route_d = route_q;
    if (wr_rt_set) route_d = set_bits(route_q, bus_wdata & PT_MASK);
    if (wr_rt_clr) route_d = clr_bits(route_q, bus_wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
    end else begin
      mask_q  <= mask_d;
      route_q <= route_d;
    end
  end

  assign status_w = masked(level_q, mask_q);

  always_comb begin
    bus_rdata = '0;
    if (hit_status) bus_rdata = status_w;
    if (hit_raw)    bus_rdata = level_q;
    if (hit_en)     bus_rdata = mask_q;
    if (hit_soft)   bus_rdata = {{(DW-1){1'b0}}, level_q[0]};
    if (hit_route)  bus_rdata = route_q;
  end

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_set |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R4
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_clr |=> ((mask_q & $past(bus_wdata)) == '0));

  // R5
  soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_soft_set && bus_wdata != '0) |=> mask_q[0]);

  // R5
  soft_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_soft_set || wr_soft_clr) && bus_wdata == '0) |=> $stable(mask_q));

  // R6
  rt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rt_clr |=> ((route_q & $past(bus_wdata)) == '0));

  // R9
  unlisted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unlisted |=> ($stable(mask_q) && $stable(route_q)));

endmodule

// File: rtl/sic_route.sv
module sic_route
  import sic_pkg::*;
#(
  parameter int PT_LO   = 21,
  parameter int PT_HI   = 30,
  parameter int SUM_IDX = 31
) (
  input  word_t level_q,
  input  word_t mask_q,
  input  word_t route_q,
  output word_t irq_out
);

  logic summary;
  assign summary = |masked(level_q, mask_q);

  for (genvar i = 0; i < DW; i++) begin : g_line
    if (i == SUM_IDX) begin : g_sum
      assign irq_out[i] = summary;
    end else if (i >= PT_LO && i <= PT_HI) begin : g_pass
      assign irq_out[i] = level_q[i] & route_q[i];
    end else begin : g_tie
      assign irq_out[i] = 1'b0;
    end
  end

endmodule

// File: rtl/sic_secondary.sv
module sic_secondary
  import sic_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int PT_LO   = 21,
  parameter int PT_HI   = 30,
  parameter int SUM_IDX = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [DW-1:0]     irq_out
);

  localparam word_t PT_MASK  = range_mask(PT_LO, PT_HI);
  localparam word_t LOW_MASK = ~(PT_MASK | range_mask(SUM_IDX, SUM_IDX));

  word_t level_w, mask_w, route_w, status_w;

  sic_level_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .level_q (level_w)
  );

  sic_regs #(.ADDR_W(ADDR_W), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .level_q   (level_w),
    .mask_q    (mask_w),
    .route_q   (route_w),
    .status_w  (status_w),
    .bus_rdata (bus_rdata)
  );

  sic_route #(.PT_LO(PT_LO), .PT_HI(PT_HI), .SUM_IDX(SUM_IDX)) u_route (
    .level_q (level_w),
    .mask_q  (mask_w),
    .route_q (route_w),
    .irq_out (irq_out)
  );

  // R3
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out[SUM_IDX] == (status_w != '0));

  // R7
  route_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & PT_MASK & ~route_w) == '0);

  // R6
  route_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_w & ~PT_MASK) == '0);

  // R8
  low_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & LOW_MASK) == '0);

endmodule

// File: tb/sim_sic_secondary.sv
`timescale 1ns/1ps
module sim_sic_secondary;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference state
  logic [31:0] m_level = '0, m_mask = '0, m_route = '0;

  always #10 clk = ~clk;

  sic_secondary u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [31:0] ref_read(input int w);
    case (w)
      0: return m_level & m_mask;
      1: return m_level;
      2: return m_mask;
      4: return {31'd0, m_level[0]};
      8: return m_route;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string read_tag(input int w);
    case (w)
      0: return "R3";
      1: return "R2";
      2: return "R4";
      4: return "R5";
      8: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] ref_out();
    logic [31:0] o;
    o = '0;
    for (int i = 21; i <= 30; i++) o[i] = m_level[i] & m_route[i];
    o[31] = ((m_level & m_mask) != 0);
    return o;
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic [31:0] e;
    e = ref_out();
    check("R3 summary line", {31'd0, irq_out[31]}, {31'd0, e[31]});
    check("R7 routed lines", irq_out & 32'h7FE0_0000, e & 32'h7FE0_0000);
    check("R8 low lines", irq_out & 32'h001F_FFFF, 32'd0);
  endtask

  // One bus cycle; effects checked in the next cycle (R10)
  task automatic step(input logic [31:0] inp, input logic wr,
                      input int w, input logic [31:0] d);
    logic [31:0] nm, nr;
    irq_in = inp;
    bus_addr = 12'(w << 2);
    bus_wr = wr;
    bus_wdata = d;
    #1;
    if (!wr) check(read_tag(w), bus_rdata, ref_read(w));
    nm = m_mask;
    nr = m_route;
    if (wr) begin
      case (w)
        2: nm = m_mask | d;
        3: nm = m_mask & ~d;
        4: if (d != 0) nm[0] = 1'b1;
        5: if (d != 0) nm[0] = 1'b0;
        8: nr = m_route | (d & 32'h7FE0_0000);
        9: nr = m_route & ~d;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    m_level = inp;
    m_mask = nm;
    m_route = nr;
    bus_wr = 1'b0;
    check_outputs();
  endtask

  task automatic read_word(input int w);
    step(irq_in, 1'b0, w, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    // R1: inputs high during reset must not show
    irq_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", irq_out, 32'd0);
    bus_addr = 12'h004; #1;
    check("R1 raw level in reset", bus_rdata, 32'd0);
    bus_addr = 12'h008; #1;
    check("R1 mask in reset", bus_rdata, 32'd0);
    bus_addr = 12'h020; #1;
    check("R1 routing in reset", bus_rdata, 32'd0);
    irq_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", irq_out, 32'd0);

    // R6: set-word filter outside 21..30
    step(32'hFFFF_FFFF, 1'b1, 8, 32'hFFFF_FFFF);
    read_word(8);
    step(32'hFFFF_FFFF, 1'b1, 9, 32'h0020_0000);
    read_word(8);
    // R5: zero data on soft words changes nothing
    step(32'h0000_0001, 1'b1, 4, 32'd0);
    read_word(2);
    step(32'h0000_0001, 1'b1, 4, 32'h0000_0100);
    read_word(2);
    read_word(0);
    step(32'h0000_0000, 1'b1, 5, 32'd0);
    read_word(2);
    step(32'h0000_0000, 1'b1, 5, 32'h8000_0000);
    read_word(2);
    read_word(4);
    // R9: unlisted words ignore writes and read as zero
    for (int w = 6; w < 16; w++) begin
      if (w != 8 && w != 9) step(32'hA5A5_A5A5, 1'b1, w, 32'hFFFF_FFFF);
    end
    step(32'hA5A5_A5A5, 1'b1, 1023, 32'hFFFF_FFFF);
    read_word(2);
    read_word(8);
    read_word(7);
    read_word(1023);
    // R4: set then clear the mask
    step(32'h8000_0010, 1'b1, 2, 32'h0000_0010);
    read_word(0);
    step(32'h8000_0010, 1'b1, 3, 32'h0000_0010);
    read_word(0);

    // Random traffic (R2 R3 R4 R5 R6 R7 R8 R9 R10)
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] inp, d;
      int w;
      inp = ($urandom % 4 == 0) ? $urandom : irq_in ^ (32'd1 << ($urandom % 32));
      w = ($urandom % 8 == 0) ? int'($urandom % 1024) : int'($urandom % 12);
      d = ($urandom % 5 == 0) ? 32'd0 : $urandom;
      step(inp, ($urandom % 2) == 1, w, d);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule